// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block steers a single DMA channel through one transaction. The transaction is built from three nested counts. A burst is 1, 2, 4 or 8 bytes moved back-to-back. A block is a programmable number of bytes. A repeat count replays the whole block, so a block of up to 65536 bytes can grow into a transaction of several megabytes. Each byte is moved as a read cycle on a byte-wide bus master port, followed by a write cycle that returns the same byte. Both cycles wait on a ready handshake.

Software loads the configuration through a one-cycle write strobe, and that strobe can also enable the channel. After that, each pulse on any of three start inputs launches exactly one burst. The inputs come from software, a peripheral and an event line. At the end of each burst the block pulses a strobe, and it raises block and transaction strobes alongside it when those boundaries are reached. An external address generator uses these strobes to reload its pointers. When the transaction completes, the channel drops its enable and sets a completion flag. A bus error response, or a configuration write while the channel is enabled, aborts the transaction and sets an error flag. Each flag has its own interrupt enable.

Top module: `dma_chan_seq`

## Requirements
- R1: Burst length code 0, 1, 2 and 3 on `cfg_burst` selects 1, 2, 4 and 8 bytes. Within a burst the bus request stays asserted from the first read until the last write is accepted.
- R2: A `cfg_block` value N from 1 to 2^BLK_W-1 gives N bytes per block, and 0 gives 2^BLK_W bytes. A burst that reaches the end of the block ends there, even if it is shorter than the burst length. The last burst of a block raises `block_end`.
- R3: A transaction moves `cfg_repeat`+1 blocks. `txn_end` is raised only with the strobe of the final burst of the final block.
- R4: A pulse on `trig_sw`, `trig_per` or `trig_evt` starts one burst only while the channel is enabled and idle. A start pulse while the channel is disabled or mid-burst is ignored.
- R5: Each byte is a read cycle (`bus_req`=1, `bus_we`=0) held until `bus_rdy`, then a write cycle (`bus_we`=1) held until `bus_rdy`. The write cycle drives the byte that was read on `bus_wdata`, and the request and its data stay stable while waiting.
- R6: `burst_end` is a one-clock pulse in the cycle after the last write of a burst is accepted. `block_end` and `txn_end` are only ever high together with `burst_end`.
- R7: A configuration write with `cfg_en`=1 while disabled enables the channel (`ch_active`=1). At the end of the transaction `ch_active` clears and `tc_flag` sets in the same cycle as `txn_end`.
- R8: `bus_err` during a bus cycle aborts the transaction. In the next cycle `bus_req` and `ch_active` are 0, `err_flag` is 1, and no strobe is raised.
- R9: A configuration write while `ch_active`=1 sets `err_flag` and clears `ch_active`.
- R10: `irq` equals (`tc_flag` AND the latched completion enable) OR (`err_flag` AND the latched error enable). A `flag_clr` pulse clears both flags.
- R11: After reset, `bus_req`, `ch_active`, all strobes, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Channel enable value written with the strobe |
| cfg_burst | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8 bytes) |
| cfg_block | input | BLK_W | Block size in bytes, 0 means 2^BLK_W |
| cfg_repeat | input | RPT_W | Additional block replays |
| cfg_tc_ie | input | 1 | Completion interrupt enable |
| cfg_err_ie | input | 1 | Error interrupt enable |
| flag_clr | input | 1 | Clears completion and error flags |
| trig_sw | input | 1 | Software start pulse |
| trig_per | input | 1 | Peripheral start pulse |
| trig_evt | input | 1 | Event start pulse |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 for write cycle, 0 for read cycle |
| bus_wdata | output | DATA_W | Byte driven on write cycles |
| bus_rdata | input | DATA_W | Byte returned on read cycles |
| bus_rdy | input | 1 | Bus cycle accepted |
| bus_err | input | 1 | Bus error response |
| burst_end | output | 1 | End-of-burst strobe |
| block_end | output | 1 | End-of-block strobe |
| txn_end | output | 1 | End-of-transaction strobe |
| ch_active | output | 1 | Channel enabled |
| tc_flag | output | 1 | Transaction complete flag |
| err_flag | output | 1 | Error flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level rules on every cycle. These are the stable request and data while a bus cycle waits, the back-to-back bytes inside a burst, the nesting and single-cycle width of the strobes, the abort response to a bus error or a clashing configuration write, and the silence of a disabled channel. Only the bench scenarios can show the counting. That means the exact number of bytes in each burst, the early cut at a block edge, the 2^BLK_W meaning of a zero block size, the number of block replays, and where the transaction strobe falls. The bench also checks the data carried from each read to its write and the interrupt gating against the latched enables.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_e;

  localparam int BURST_CODE_W = 2;
  localparam int BURST_CNT_W  = 4;

  // Byte count of a burst from its code: 1, 2, 4 or 8.
  function automatic logic [BURST_CNT_W-1:0] burst_bytes(input logic [BURST_CODE_W-1:0] code);
    return BURST_CNT_W'(1) << code;
  endfunction
endpackage

// File: rtl/dma_burst_ctr.sv
module dma_burst_ctr
  import dma_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   step,
  input  logic [BURST_CNT_W-1:0] len,
  output logic                   last
);
  logic [BURST_CNT_W-1:0] done_q;

  assign last = (done_q + BURST_CNT_W'(1)) == len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      done_q <= '0;
    else if (clr || (step && last))  done_q <= '0;
    else if (step)                   done_q <= done_q + BURST_CNT_W'(1);
  end
endmodule

// File: rtl/dma_down_ctr.sv
module dma_down_ctr #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         last
);
  logic [W-1:0] left_q;

  assign last = left_q == W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     left_q <= '0;
    else if (load)  left_q <= load_val;
    else if (step)  left_q <= left_q - W'(1);
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int BLK_W  = 16,
  parameter int RPT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_en,
  input  logic [BURST_CODE_W-1:0] cfg_burst,
  input  logic [BLK_W-1:0]        cfg_block,
  input  logic [RPT_W-1:0]        cfg_repeat,
  input  logic                    cfg_tc_ie,
  input  logic                    cfg_err_ie,
  input  logic                    flag_clr,
  input  logic                    trig_sw,
  input  logic                    trig_per,
  input  logic                    trig_evt,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic [DATA_W-1:0]       bus_rdata,
  input  logic                    bus_rdy,
  input  logic                    bus_err,
  output logic                    burst_end,
  output logic                    block_end,
  output logic                    txn_end,
  output logic                    ch_active,
  output logic                    tc_flag,
  output logic                    err_flag,
  output logic                    irq
);
  localparam int BLEN_W = BLK_W + 1;
  localparam int RCNT_W = RPT_W + 1;

  // Block length in bytes; a zero field stands for the full 2^BLK_W.
  function automatic logic [BLEN_W-1:0] block_bytes(input logic [BLK_W-1:0] sz);
    if (sz == '0) return BLEN_W'(1) << BLK_W;
    return BLEN_W'(sz);
  endfunction

  // Number of blocks in a transaction.
  function automatic logic [RCNT_W-1:0] block_total(input logic [RPT_W-1:0] rpt);
    return RCNT_W'(rpt) + RCNT_W'(1);
  endfunction

  seq_state_e              state_q, state_nx;
  logic [BURST_CODE_W-1:0] burst_code_q;
  logic [BLEN_W-1:0]       blk_len_q;
  logic [DATA_W-1:0]       data_q;
  logic                    tc_ie_q, err_ie_q, ch_en_q, tc_q, err_q;
  logic                    burst_end_q, block_end_q, txn_end_q;

  // Named internal events
  logic cfg_accept, cfg_clash, trig_any, burst_go, read_done, byte_done;
  logic bus_fault, abort;
  logic burst_last, blk_last, rpt_last, burst_fin, blk_fin, txn_fin;

  assign cfg_accept = cfg_we && !ch_en_q;
  assign cfg_clash  = cfg_we && ch_en_q;
  assign trig_any   = trig_sw || trig_per || trig_evt;
  assign bus_fault  = (state_q != SEQ_IDLE) && bus_err;
  assign abort      = cfg_clash || bus_fault;
  assign burst_go   = (state_q == SEQ_IDLE) && ch_en_q && trig_any && !abort;
  assign read_done  = (state_q == SEQ_READ) && bus_rdy && !abort;
  assign byte_done  = (state_q == SEQ_WRITE) && bus_rdy && !abort;
  assign burst_fin  = byte_done && (burst_last || blk_last);
  assign blk_fin    = byte_done && blk_last;
  assign txn_fin    = blk_fin && rpt_last;

  dma_burst_ctr u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (abort || blk_fin || cfg_accept),
    .step  (byte_done),
    .len   (burst_bytes(burst_code_q)),
    .last  (burst_last)
  );

  dma_down_ctr #(.W(BLEN_W)) u_block (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_accept || blk_fin),
    .load_val (cfg_accept ? block_bytes(cfg_block) : blk_len_q),
    .step     (byte_done),
    .last     (blk_last)
  );

  dma_down_ctr #(.W(RCNT_W)) u_repeat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_accept),
    .load_val (block_total(cfg_repeat)),
    .step     (blk_fin),
    .last     (rpt_last)
  );

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (burst_go)  state_nx = SEQ_READ;
      SEQ_READ:  if (read_done) state_nx = SEQ_WRITE;
      SEQ_WRITE: if (byte_done) state_nx = burst_fin ? SEQ_IDLE : SEQ_READ;
      default:                  state_nx = SEQ_IDLE;
    endcase
    if (abort) state_nx = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_IDLE;
      burst_code_q <= '0;
      blk_len_q    <= '0;
      tc_ie_q      <= 1'b0;
      err_ie_q     <= 1'b0;
      ch_en_q      <= 1'b0;
      data_q       <= '0;
      burst_end_q  <= 1'b0;
      block_end_q  <= 1'b0;
      txn_end_q    <= 1'b0;
      tc_q         <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      state_q <= state_nx;
      if (cfg_accept) begin
        burst_code_q <= cfg_burst;
        blk_len_q    <= block_bytes(cfg_block);
        tc_ie_q      <= cfg_tc_ie;
        err_ie_q     <= cfg_err_ie;
      end
      if (abort || txn_fin) ch_en_q <= 1'b0;
      else if (cfg_accept)  ch_en_q <= cfg_en;
      if (read_done) data_q <= bus_rdata;
      burst_end_q <= burst_fin;
      block_end_q <= blk_fin;
      txn_end_q   <= txn_fin;
      if (txn_fin)       tc_q <= 1'b1;
      else if (flag_clr) tc_q <= 1'b0;
      if (abort)         err_q <= 1'b1;
      else if (flag_clr) err_q <= 1'b0;
    end
  end

  assign bus_req   = state_q != SEQ_IDLE;
  assign bus_we    = state_q == SEQ_WRITE;
  assign bus_wdata = data_q;
  assign burst_end = burst_end_q;
  assign block_end = block_end_q;
  assign txn_end   = txn_end_q;
  assign ch_active = ch_en_q;
  assign tc_flag   = tc_q;
  assign err_flag  = err_q;
  assign irq       = (tc_q && tc_ie_q) || (err_q && err_ie_q);
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              bus_req,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rdy,
  input logic              bus_err,
  input logic              burst_end,
  input logic              block_end,
  input logic              txn_end,
  input logic              ch_active,
  input logic              tc_flag,
  input logic              err_flag
);
  // R1
  burst_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_rdy && !bus_err && !cfg_we) |=> (bus_req || burst_end));

  // R5
  wait_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rdy && !bus_err && !(cfg_we && ch_active))
      |=> (bus_req && $stable(bus_we) && $stable(bus_wdata)));

  // R6
  burst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !burst_end);

  // R6
  block_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |-> burst_end);

  // R6
  txn_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end |-> block_end);

  // R7
  txn_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end |-> (!ch_active && tc_flag));

  // R8
  bus_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err) |=> (!bus_req && err_flag && !ch_active && !burst_end));

  // R9
  cfg_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && ch_active) |=> (err_flag && !ch_active));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_active && !bus_req) |=> !bus_req);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdy   (bus_rdy),
  .bus_err   (bus_err),
  .burst_end (burst_end),
  .block_end (block_end),
  .txn_end   (txn_end),
  .ch_active (ch_active),
  .tc_flag   (tc_flag),
  .err_flag  (err_flag)
);

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
  localparam int BLK_W  = 8;
  localparam int RPT_W  = 8;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              cfg_we = 0, cfg_en = 0, cfg_tc_ie = 0, cfg_err_ie = 0, flag_clr = 0;
  logic [1:0]        cfg_burst = '0;
  logic [BLK_W-1:0]  cfg_block = '0;
  logic [RPT_W-1:0]  cfg_repeat = '0;
  logic              trig_sw = 0, trig_per = 0, trig_evt = 0;
  logic              bus_req, bus_we;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic              bus_rdy = 0, bus_err = 0;
  logic              burst_end, block_end, txn_end, ch_active, tc_flag, err_flag, irq;

  dma_chan_seq #(.BLK_W(BLK_W), .RPT_W(RPT_W), .DATA_W(DATA_W)) i_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_burst(cfg_burst),
    .cfg_block(cfg_block), .cfg_repeat(cfg_repeat), .cfg_tc_ie(cfg_tc_ie),
    .cfg_err_ie(cfg_err_ie), .flag_clr(flag_clr), .trig_sw(trig_sw), .trig_per(trig_per),
    .trig_evt(trig_evt), .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .bus_err(bus_err), .burst_end(burst_end),
    .block_end(block_end), .txn_end(txn_end), .ch_active(ch_active), .tc_flag(tc_flag),
    .err_flag(err_flag), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_burst(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int exp_block(input int sz);
    return (sz == 0) ? (2 ** BLK_W) : sz;
  endfunction

  task automatic configure(input bit en, input int code, input int blk, input int rpt,
                           input bit tc_ie, input bit err_ie);
    @(negedge clk);
    cfg_we = 1; cfg_en = en; cfg_burst = 2'(code); cfg_block = BLK_W'(blk);
    cfg_repeat = RPT_W'(rpt); cfg_tc_ie = tc_ie; cfg_err_ie = err_ie;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic start(input int src);
    @(negedge clk);
    trig_sw = (src == 0); trig_per = (src == 1); trig_evt = (src == 2);
    @(negedge clk);
    trig_sw = 0; trig_per = 0; trig_evt = 0;
  endtask

  task automatic run_burst(input int nbytes, input bit exp_blk, input bit exp_txn, input bit mid);
    int rd = 0, wr = 0, guard = 0;
    bit expect_wr = 0, done = 0, mid_done = 0;
    logic [DATA_W-1:0] last_rd = '0;
    start($urandom_range(0, 2));
    while (!done) begin
      trig_sw = 0; trig_per = 0; trig_evt = 0; bus_rdy = 0;
      if (burst_end) begin
        done = 1;
        check(wr == nbytes, "R1/R2 bytes in burst", wr, nbytes);
        check(block_end == exp_blk, "R2 block_end", block_end, exp_blk);
        check(txn_end == exp_txn, "R3 txn_end", txn_end, exp_txn);
        check(ch_active == !exp_txn, "R7 ch_active at burst end", ch_active, !exp_txn);
      end else if (!bus_req || guard > 100) begin
        check(0, "R1 burst not back-to-back", bus_req, 1);
        done = 1;
      end else begin
        if (mid && !mid_done && rd == 1) begin trig_evt = 1; mid_done = 1; end
        if ($urandom_range(0, 2) != 0) begin
          bus_rdy = 1;
          if (bus_we) begin
            check(expect_wr, "R5 write without read", 1, 0);
            check(bus_wdata == last_rd, "R5 write data", bus_wdata, last_rd);
            wr++; expect_wr = 0;
          end else begin
            check(!expect_wr, "R5 read before write", 0, 1);
            bus_rdata = DATA_W'($urandom);
            last_rd = bus_rdata; rd++; expect_wr = 1;
          end
        end
        guard++;
        @(negedge clk);
      end
    end
    if (mid) begin
      @(negedge clk);
      check(!bus_req, "R4 mid-burst start ignored", bus_req, 0);
      @(negedge clk);
      check(!bus_req, "R4 mid-burst start ignored later", bus_req, 0);
    end
  endtask

  task automatic run_txn(input int code, input int blk, input int rpt, input bit tc_ie, input bit mid);
    int bl, bb, rem, n;
    bit m = mid;
    configure(1, code, blk, rpt, tc_ie, 0);
    check(ch_active == 1, "R7 enable on config", ch_active, 1);
    bl = exp_burst(code);
    bb = exp_block(blk);
    for (int b = 0; b <= rpt; b++) begin
      rem = bb;
      while (rem > 0) begin
        n = (rem < bl) ? rem : bl;
        rem -= n;
        run_burst(n, rem == 0, (rem == 0) && (b == rpt), m);
        m = 0;
      end
    end
    check(tc_flag == 1, "R7 tc_flag", tc_flag, 1);
    check(irq == tc_ie, "R10 irq on completion", irq, tc_ie);
    check(err_flag == 0, "R8 no error on clean txn", err_flag, 0);
    clear_flags();
    check(tc_flag == 0 && irq == 0, "R10 flag_clr", tc_flag, 0);
  endtask

  task automatic err_abort(input bit in_write);
    configure(1, 0, 4, 0, 0, 1);
    start(1);
    if (in_write) begin
      bus_rdata = 8'h5a; bus_rdy = 1;
      @(negedge clk);
      bus_rdy = 0;
    end
    check(bus_req == 1 && bus_we == in_write, "R5 cycle kind before error", bus_we, in_write);
    bus_err = 1;
    @(negedge clk);
    bus_err = 0;
    check(bus_req == 0, "R8 request dropped", bus_req, 0);
    check(err_flag == 1 && ch_active == 0, "R8 error flag and disable", err_flag, 1);
    check(burst_end == 0, "R8 no strobe on abort", burst_end, 0);
    check(irq == 1, "R10 error irq", irq, 1);
    clear_flags();
    check(err_flag == 0, "R10 error flag cleared", err_flag, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    check(!bus_req && !ch_active && !burst_end && !block_end && !txn_end, "R11 reset outputs", bus_req, 0);
    check(!tc_flag && !err_flag && !irq, "R11 reset flags", irq, 0);

    // R4: start pulses while disabled are ignored
    start(0);
    check(!bus_req, "R4 start while disabled", bus_req, 0);

    // R2 early cut and R3 replays
    run_txn(1, 3, 2, 1, 1);
    // R2 zero block size means 2^BLK_W
    run_txn(3, 0, 1, 0, 0);
    run_txn(0, 1, 0, 1, 0);
    run_txn(2, 4, 3, 1, 0);

    for (int i = 0; i < 30; i++)
      run_txn($urandom_range(0, 3), $urandom_range(1, 20), $urandom_range(0, 3),
              1'($urandom_range(0, 1)), 0);

    // R8 bus error in read and in write
    err_abort(0);
    err_abort(1);

    // R9 configuration write while enabled
    configure(1, 2, 8, 0, 1, 0);
    check(ch_active == 1, "R7 enabled", ch_active, 1);
    configure(1, 2, 8, 0, 1, 0);
    check(err_flag == 1 && ch_active == 0, "R9 clash aborts", ch_active, 0);
    check(irq == 0, "R10 error irq masked", irq, 1'b0);
    start(2);
    check(!bus_req, "R4 start after clash ignored", bus_req, 0);
    clear_flags();

    // R7 configuration with enable low leaves channel off
    configure(0, 0, 2, 0, 0, 0);
    check(ch_active == 0, "R7 enable low", ch_active, 0);
    start(0);
    check(!bus_req, "R4 start with enable low", bus_req, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule